// File: doc/BRIEF.md
# Chip-Select Window Address Decoder

This block compares each bus address against eight programmable chip-select windows. Every window has a base, a size code and an enable bit. For an access that falls inside a window, the block reports which chip select was hit as a one-hot vector, along with the byte offset inside that window. It also picks one of three downstream targets. Plain memory devices go to the memory port. NAND devices go to the NAND data port, unless the prefetch engine is switched on and assigned to that chip select; in that case they go to the prefetch FIFO port.

Configuration is written one register at a time. Each chip select has two registers: a window register and a device-type register. All decode results are registered, so the outcome of an access presented on one clock edge appears after that edge. An access presented in the same cycle as a configuration write is decoded with the configuration that existed before the write.

Top module: `cs_window_decoder`

## Requirements
- R1: A write with `cfg_we`=1 and `cfg_is_dev`=0 loads the window register of chip select `cfg_cs` from `cfg_wdata`. Base is taken from bits 5:0, the enable flag from bit 6 and the size code from bits 11:8. The new value applies to accesses presented from the next cycle onward. An access presented in the write cycle uses the old value.
- R2: An address hits an enabled window when all three of these hold: bits 31:30 are zero; bits 29:28 equal base bits 5:4; and bits 27:24 equal base bits 3:0 in every position where the size code has a 1. Size codes F, E, C and 8 give windows of 16, 32, 64 and 128 MB.
- R3: `cs_offset` equals the address with bits 31:28 cleared and with bits 27:24 cleared wherever the size code has a 1. When there is no hit, `cs_offset` is zero.
- R4: A window whose enable flag is clear never hits.
- R5: After reset, every window register holds 0xF00 and every device type is 0. Chip select 0 additionally has its enable flag set, so it hits addresses 0x00000000 to 0x00FFFFFF.
- R6: `mask_bad[i]` is 1 when window i holds a size code other than 8, C, E or F. Code 0 is exempt when the parameter `ALLOW_MASK0` is set. A window with code 0 still decodes as a 256 MB window.
- R7: A write with `cfg_we`=1 and `cfg_is_dev`=1 loads the device type of chip select `cfg_cs` from `cfg_wdata` bits 11:10. A hit on a chip select with type 0 gives `cs_route`=1 (memory).
- R8: A hit on a chip select with a non-zero type gives `cs_route`=3 (prefetch FIFO) when `pf_en`=1 and `pf_cs` equals that chip select. Otherwise it gives `cs_route`=2 (NAND data).
- R9: When several enabled windows match one address, only the lowest-numbered chip select is reported.
- R10: An access that matches no window gives `cs_miss`=1, `cs_hit`=0 and `cs_route`=0 for one cycle.
- R11: Outputs are registered. The result of an access sampled on a clock edge is visible after that edge. In a cycle that follows no access, `cs_hit`, `cs_offset`, `cs_route` and `cs_miss` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_dev | input | 1 | 1 selects the device-type register, 0 selects the window register |
| cfg_cs | input | 3 | Chip select being configured |
| cfg_wdata | input | 12 | Configuration write data |
| pf_en | input | 1 | Prefetch engine enabled |
| pf_cs | input | 3 | Chip select that owns the prefetch engine |
| acc_valid | input | 1 | Access address is valid |
| acc_addr | input | 32 | Access address |
| cs_hit | output | 8 | One-hot chip select that was hit |
| cs_offset | output | 32 | Offset inside the hit window |
| cs_route | output | 2 | Target: 0 none, 1 memory, 2 NAND data, 3 prefetch FIFO |
| cs_miss | output | 1 | Access matched no window |
| mask_bad | output | 8 | Per-window flag for an illegal size code |

## Verification
The vector table places addresses at the first and last byte of windows that use each size code. This separates the four masking widths, in both the hit test and the offset. The table also includes addresses that differ from a window only in a masked or unmasked nibble, in bits 29:28, or in bit 30, which tells a real miss apart from a decode that is too loose. Further patterns cover overlapping windows to expose the priority order, and one address under several prefetch owner and enable settings to separate the three routes. A write and an access issued in the same cycle show whether the old configuration is still in force.

// File: rtl/cswd_pkg.sv
package cswd_pkg;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_MEM  = 2'd1,
        RT_NAND = 2'd2,
        RT_FIFO = 2'd3
    } route_e;

    // One window register: size code, enable flag, base
    typedef struct packed {
        logic [3:0] mask;
        logic       valid;
        logic [5:0] base;
    } win_t;

endpackage

// File: rtl/cswd_window_regs.sv
module cswd_window_regs
    import cswd_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int CS_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic                      is_dev,
    input  logic [CS_W-1:0]           sel,
    input  logic [11:0]               wdata,
    output win_t [NUM_CS-1:0]         win_o,
    output logic [NUM_CS-1:0][1:0]    dtype_o
);

    typedef struct packed {
        win_t [NUM_CS-1:0]      win;
        logic [NUM_CS-1:0][1:0] dtype;
    } regs_t;

    regs_t r_d, r_q;

    // bit 7 of the window register carries no function
    logic unused_bit7;
    assign unused_bit7 = wdata[7];

    always_comb begin
        r_d = r_q;
        if (we) begin
            if (is_dev) begin
                r_d.dtype[sel] = wdata[11:10];
            end else begin
                r_d.win[sel].mask  = wdata[11:8];
                r_d.win[sel].valid = wdata[6];
                r_d.win[sel].base  = wdata[5:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CS; i++) begin
                r_q.win[i].mask  <= 4'hF;
                r_q.win[i].valid <= (i == 0);
                r_q.win[i].base  <= 6'd0;
                r_q.dtype[i]     <= 2'd0;
            end
        end else begin
            r_q <= r_d;
        end
    end

    assign win_o   = r_q.win;
    assign dtype_o = r_q.dtype;

    AST_WIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !is_dev) |=> (win_o[$past(sel)] ==
            {$past(wdata[11:8]), $past(wdata[6]), $past(wdata[5:0])})); // R1

endmodule

// File: rtl/cswd_match.sv
module cswd_match
    import cswd_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter bit ALLOW_MASK0 = 1'b0
) (
    input  win_t              win,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] offset,
    output logic              mask_bad
);

    localparam int SEL_LSB = ADDR_W - 8;   // lowest address bit under the base

    logic [1:0] a_top;
    logic [1:0] a_hi;
    logic [3:0] a_lo;
    logic       legal;

    assign a_top = addr[ADDR_W-1 -: 2];
    assign a_hi  = addr[SEL_LSB+4 +: 2];
    assign a_lo  = addr[SEL_LSB +: 4];

    always_comb begin
        hit = win.valid && (a_top == 2'b00) && (a_hi == win.base[5:4])
              && (((a_lo ^ win.base[3:0]) & win.mask) == 4'h0);
        offset = '0;
        offset[SEL_LSB-1:0]  = addr[SEL_LSB-1:0];
        offset[SEL_LSB +: 4] = a_lo & ~win.mask;
    end

    always_comb begin
        case (win.mask)
            4'h8, 4'hC, 4'hE, 4'hF: legal = 1'b1;
            4'h0:                   legal = ALLOW_MASK0;
            default:                legal = 1'b0;
        endcase
        mask_bad = !legal;
    end

endmodule

// File: rtl/cswd_route.sv
module cswd_route
    import cswd_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int CS_W   = 3,
    parameter int ADDR_W = 32
) (
    input  logic [NUM_CS-1:0]             hit,
    input  logic [NUM_CS-1:0][ADDR_W-1:0] offs,
    input  logic [NUM_CS-1:0][1:0]        dtype,
    input  logic                          pf_en,
    input  logic [CS_W-1:0]               pf_cs,
    output logic [NUM_CS-1:0]             sel,
    output logic [ADDR_W-1:0]             offset,
    output route_e                        route
);

    // walk from the top down so the lowest matching chip select is kept
    always_comb begin
        sel    = '0;
        offset = '0;
        route  = RT_NONE;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel    = '0;
                sel[i] = 1'b1;
                offset = offs[i];
                if (dtype[i] == 2'd0) begin
                    route = RT_MEM;
                end else if (pf_en && (pf_cs == CS_W'(i))) begin
                    route = RT_FIFO;
                end else begin
                    route = RT_NAND;
                end
            end
        end
    end

endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
    import cswd_pkg::*;
#(
    parameter int NUM_CS      = 8,
    parameter int ADDR_W      = 32,
    parameter bit ALLOW_MASK0 = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic                      cfg_is_dev,
    input  logic [$clog2(NUM_CS)-1:0] cfg_cs,
    input  logic [11:0]               cfg_wdata,
    input  logic                      pf_en,
    input  logic [$clog2(NUM_CS)-1:0] pf_cs,
    input  logic                      acc_valid,
    input  logic [ADDR_W-1:0]         acc_addr,
    output logic [NUM_CS-1:0]         cs_hit,
    output logic [ADDR_W-1:0]         cs_offset,
    output logic [1:0]                cs_route,
    output logic                      cs_miss,
    output logic [NUM_CS-1:0]         mask_bad
);

    localparam int CS_W = $clog2(NUM_CS);

    typedef struct packed {
        logic [NUM_CS-1:0] sel;
        logic [ADDR_W-1:0] offset;
        route_e            route;
        logic              miss;
    } out_t;

    win_t [NUM_CS-1:0]             win;
    logic [NUM_CS-1:0][1:0]        dtype;
    logic [NUM_CS-1:0]             hit_vec;
    logic [NUM_CS-1:0][ADDR_W-1:0] offs;
    logic [NUM_CS-1:0]             pick_sel;
    logic [ADDR_W-1:0]             pick_off;
    route_e                        pick_route;
    out_t                          out_d, out_q;

    cswd_window_regs #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .is_dev  (cfg_is_dev),
        .sel     (cfg_cs),
        .wdata   (cfg_wdata),
        .win_o   (win),
        .dtype_o (dtype)
    );

    for (genvar g = 0; g < NUM_CS; g++) begin : g_win
        cswd_match #(.ADDR_W(ADDR_W), .ALLOW_MASK0(ALLOW_MASK0)) u_match (
            .win      (win[g]),
            .addr     (acc_addr),
            .hit      (hit_vec[g]),
            .offset   (offs[g]),
            .mask_bad (mask_bad[g])
        );

        AST_VALID_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            out_q.sel[g] |-> $past(win[g].valid)); // R4
    end

    cswd_route #(.NUM_CS(NUM_CS), .CS_W(CS_W), .ADDR_W(ADDR_W)) u_route (
        .hit    (hit_vec),
        .offs   (offs),
        .dtype  (dtype),
        .pf_en  (pf_en),
        .pf_cs  (pf_cs),
        .sel    (pick_sel),
        .offset (pick_off),
        .route  (pick_route)
    );

    always_comb begin
        out_d = '0;
        if (acc_valid) begin
            out_d.sel    = pick_sel;
            out_d.offset = pick_off;
            out_d.route  = pick_route;
            out_d.miss   = (pick_sel == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign cs_hit    = out_q.sel;
    assign cs_offset = out_q.offset;
    assign cs_route  = out_q.route;
    assign cs_miss   = out_q.miss;

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_hit)); // R9

    AST_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        cs_miss |-> (cs_hit == '0) && (cs_route == 2'd0)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_valid) |-> (cs_hit == '0) && !cs_miss && (cs_offset == '0)); // R11

    AST_ROUTE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hit != '0) |-> (cs_route != 2'd0)); // R7

    AST_OFFSET_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hit != '0) |-> (cs_offset[ADDR_W-1 -: 4] == 4'h0)); // R3

endmodule

// File: tb/sim_cs_window_decoder.sv
module sim_cs_window_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    // {addr, hit, offset, route, miss}
    localparam logic [74:0] VEC [NV] = '{
        {32'h0012_3456, 8'h01, 32'h0012_3456, 2'd1, 1'b0},
        {32'h02AB_CDEF, 8'h02, 32'h00AB_CDEF, 2'd3, 1'b0},
        {32'h0500_1234, 8'h04, 32'h0100_1234, 2'd2, 1'b0},
        {32'h04FF_FFFF, 8'h04, 32'h00FF_FFFF, 2'd2, 1'b0},
        {32'h0B00_0010, 8'h08, 32'h0300_0010, 2'd1, 1'b0},
        {32'h17FF_FFFC, 8'h10, 32'h07FF_FFFC, 2'd1, 1'b0},
        {32'h2000_0000, 8'h00, 32'h0000_0000, 2'd0, 1'b1},
        {32'h3ABC_DEF0, 8'h80, 32'h0ABC_DEF0, 2'd1, 1'b0},
        {32'h4000_0000, 8'h00, 32'h0000_0000, 2'd0, 1'b1},
        {32'h1800_0000, 8'h00, 32'h0000_0000, 2'd0, 1'b1},
        {32'h01FF_FFFF, 8'h00, 32'h0000_0000, 2'd0, 1'b1},
        {32'h0600_0000, 8'h00, 32'h0000_0000, 2'd0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_is_dev;
    logic [2:0]  cfg_cs;
    logic [11:0] cfg_wdata;
    logic        pf_en;
    logic [2:0]  pf_cs;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic [7:0]  cs_hit;
    logic [31:0] cs_offset;
    logic [1:0]  cs_route;
    logic        cs_miss;
    logic [7:0]  mask_bad;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_window_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_is_dev(cfg_is_dev),
        .cfg_cs(cfg_cs), .cfg_wdata(cfg_wdata), .pf_en(pf_en), .pf_cs(pf_cs),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .cs_hit(cs_hit),
        .cs_offset(cs_offset), .cs_route(cs_route), .cs_miss(cs_miss),
        .mask_bad(mask_bad)
    );

    task automatic check_out(input string req, input logic [7:0] eh,
                             input logic [31:0] eo, input logic [1:0] er,
                             input logic em);
        n_checks++;
        if (cs_hit !== eh || cs_offset !== eo || cs_route !== er || cs_miss !== em) begin
            n_fail++;
            $display("FAIL %s: got hit=%h off=%h route=%0d miss=%0b, expected hit=%h off=%h route=%0d miss=%0b",
                     req, cs_hit, cs_offset, cs_route, cs_miss, eh, eo, er, em);
        end
    endtask

    task automatic check_bad(input string req, input logic [7:0] exp);
        n_checks++;
        if (mask_bad !== exp) begin
            n_fail++;
            $display("FAIL %s: got mask_bad=%h, expected %h", req, mask_bad, exp);
        end
    endtask

    task automatic wr(input logic dev, input logic [2:0] cs, input logic [11:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_is_dev = dev; cfg_cs = cs; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [31:0] a);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_is_dev = 1'b0; cfg_cs = '0;
        cfg_wdata = '0; pf_en = 1'b0; pf_cs = '0; acc_valid = 1'b0; acc_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 / R11: quiet outputs and default windows after reset
        check_out("R11 idle after reset", 8'h00, 32'h0, 2'd0, 1'b0);
        check_bad("R5 reset size codes legal", 8'h00);
        access(32'h00FF_FFFF);
        check_out("R5 cs0 enabled at reset", 8'h01, 32'h00FF_FFFF, 2'd1, 1'b0);
        access(32'h0200_0000);
        check_out("R5 cs1 disabled at reset", 8'h00, 32'h0, 2'd0, 1'b1);

        // configure windows (R1) and device types (R7)
        wr(1'b0, 3'd1, 12'hF42);
        wr(1'b0, 3'd2, 12'hE44);
        wr(1'b0, 3'd3, 12'hC48);
        wr(1'b0, 3'd4, 12'h850);
        wr(1'b0, 3'd5, 12'hF20);
        wr(1'b0, 3'd6, 12'hF45);
        wr(1'b0, 3'd7, 12'h070);
        wr(1'b1, 3'd1, 12'h800);
        wr(1'b1, 3'd2, 12'h800);
        check_bad("R6 code 0 flagged", 8'h80);
        pf_en = 1'b1; pf_cs = 3'd1;

        // table: R2 R3 R4 R6 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][74:43]);
            check_out($sformatf("R2/R3/R9/R10 vector %0d", i),
                      VEC[i][42:35], VEC[i][34:3], VEC[i][2:1], VEC[i][0]);
        end

        // R8: prefetch ownership moves to cs2
        pf_cs = 3'd2;
        access(32'h0400_0000);
        check_out("R8 owner cs2 to fifo", 8'h04, 32'h0, 2'd3, 1'b0);
        access(32'h0200_0000);
        check_out("R8 former owner to nand", 8'h02, 32'h0, 2'd2, 1'b0);
        pf_en = 1'b0;
        access(32'h0400_0010);
        check_out("R8 engine off to nand", 8'h04, 32'h10, 2'd2, 1'b0);

        // R7: change cs2 back to memory type
        wr(1'b1, 3'd2, 12'h000);
        access(32'h0400_0020);
        check_out("R7 type 0 to memory", 8'h04, 32'h20, 2'd1, 1'b0);

        // R1: write and access in the same cycle use old config
        @(negedge clk);
        cfg_we = 1'b1; cfg_is_dev = 1'b0; cfg_cs = 3'd5; cfg_wdata = 12'hF60;
        acc_valid = 1'b1; acc_addr = 32'h2000_0010;
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0;
        check_out("R1 same-cycle uses old window", 8'h00, 32'h0, 2'd0, 1'b1);
        access(32'h2000_0010);
        check_out("R1 next cycle uses new window", 8'h20, 32'h10, 2'd1, 1'b0);

        // R4: disable cs0
        wr(1'b0, 3'd0, 12'hF00);
        access(32'h0000_0004);
        check_out("R4 disabled window never hits", 8'h00, 32'h0, 2'd0, 1'b1);

        // R11: no access gives quiet outputs
        @(negedge clk);
        check_out("R11 idle cycle", 8'h00, 32'h0, 2'd0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule